// File: doc/BRIEF.md
# Codec Serial Port Word/Byte Framer

This block is the digital half of a converter-style synchronous serial port that exchanges samples with a signal processor. It divides the fabric clock by a fixed ratio to make a bit clock. It sends a twos-complement converter sample out, most significant bit first, inside an active-low output frame. It also frames the word the processor shifts in, using a second active-low frame, and delivers that word on a parallel output with a one-cycle valid flag.

Each lane starts when its start input is pulsed for one cycle. The format input, sampled at that moment, selects one 16-bit transfer or two 8-bit transfers. Each lane drives an active-low end-of-transfer strobe. In word format the strobe is a single pulse after the last bit. In byte format the strobe is a level that marks the second byte, so an 8-bit host can tell the two bytes apart.

Top module: `ssp_framer`

## Requirements
- R1: `bclk_o` runs at the `clk` frequency divided by 4, high for two `clk` cycles and low for two. Every lane output changes only on `clk` edges where `bclk_o` rises. `sdi_i` is sampled on the edges where `bclk_o` falls.
- R2: Each frame output (`sdo_frm_n_o`, `sdi_frm_n_o`) is low for exactly the bit periods of the transfer: 16 bit-clock periods in word format, or two runs of 8 periods separated by one high period in byte format.
- R3: `sdo_o` carries the latched sample MSB first, one bit per bit-clock period. The MSB (the sign bit) is on `sdo_o` for the whole bit-clock period before the frame falls. In byte format, bit 7 is on `sdo_o` during the high period before the second byte.
- R4: In word format, the end strobe goes low for exactly one bit-clock period, starting at the edge where the frame returns high after bit 0.
- R5: In byte format, the end strobe goes low at the edge where the first byte's frame returns high. It stays low through the gap period and the whole second byte, and returns high together with the frame after bit 0.
- R6: `fmt_word_i` = 1 at the start pulse selects word format and 0 selects byte format. The value is held for the whole transfer, whatever the input does later.
- R7: While `rst` is high (synchronous), `bclk_o` is held high, both frames and both end strobes are high, and both busy flags are low.
- R8: A start pulse is accepted only while its lane's busy flag is low. A start pulse seen while busy has no effect on the transfer in progress. Busy stays high from the cycle after an accepted start until the end strobe has been produced. The lane's first bit-clock period then begins at the next rising edge of `bclk_o`.
- R9: The receive lane shifts `sdi_i` in MSB first; in byte format the first byte becomes bits 15:8. On the edge where the last data period ends, `rx_data_o` takes the word and `rx_valid_o` is high for one `clk` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_word_i | input | 1 | 1 = one 16-bit transfer, 0 = two 8-bit transfers; sampled at start |
| tx_start_i | input | 1 | One-cycle request to send `tx_data_i` |
| tx_data_i | input | 16 | Twos-complement sample to send |
| tx_busy_o | output | 1 | Send lane busy |
| rx_start_i | input | 1 | One-cycle request to frame an incoming word |
| rx_busy_o | output | 1 | Receive lane busy |
| rx_data_o | output | 16 | Last word received |
| rx_valid_o | output | 1 | One-cycle flag for a new `rx_data_o` |
| bclk_o | output | 1 | Bit clock, `clk`/4 |
| sdo_o | output | 1 | Serial sample output |
| sdo_frm_n_o | output | 1 | Active-low frame for `sdo_o` |
| sdo_end_n_o | output | 1 | Active-low end strobe of the send lane |
| sdi_i | input | 1 | Serial word input |
| sdi_frm_n_o | output | 1 | Active-low frame for `sdi_i` |
| sdi_end_n_o | output | 1 | Active-low end strobe of the receive lane |

## Verification
The hardest cases to reach are the ones where a control event lands on a particular phase of the divided clock. These are a start pulse that arrives on the same edge as a bit-clock rise, a second start that arrives while the lane is busy, and a reset that arrives in the middle of a byte-format transfer. The stimulus issues starts after varied numbers of idle cycles, so that they fall on every divider phase. It re-pulses start with a different value partway through a transfer, and it drops reset into the second byte of a transfer. The reference model follows both lanes period by period, so every cycle after these events is compared.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ARM,
    SEQ_LEAD,
    SEQ_SHIFT,
    SEQ_GAP,
    SEQ_STROBE
  } seq_state_e;
endpackage

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic bclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (cnt_q == CW'(DIV - 1)) cnt_nxt = '0;
    else                       cnt_nxt = cnt_q + 1'b1;
  end

  // event flags: the edge that ends this count value moves bclk
  assign rise_o = (cnt_q == CW'(DIV - 1));
  assign fall_o = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bclk_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      bclk_o <= (cnt_nxt < CW'(HALF));
    end
  end
endmodule

// File: rtl/ssp_frame_seq.sv
module ssp_frame_seq
  import ssp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic start_i,
  input  logic fmt_word_i,
  output logic busy_o,
  output logic accept_o,
  output logic in_shift_o,
  output logic done_o,
  output logic frm_n_o,
  output logic end_n_o
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int BW     = $clog2(WORD_W);

  seq_state_e state_q, state_nxt;
  logic [BW-1:0] bit_q;
  logic          hi_q;
  logic          byte_q;
  logic          last_bit;

  assign last_bit   = byte_q ? (bit_q == BW'(BYTE_W - 1)) : (bit_q == BW'(WORD_W - 1));
  assign busy_o     = (state_q != SEQ_IDLE);
  assign accept_o   = (state_q == SEQ_IDLE) && start_i;
  assign in_shift_o = (state_q == SEQ_SHIFT);
  assign done_o     = rise_i && (state_q == SEQ_SHIFT) && last_bit && (!byte_q || hi_q);

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      SEQ_IDLE:   if (start_i) state_nxt = SEQ_ARM;
      SEQ_ARM:    if (rise_i) state_nxt = SEQ_LEAD;
      SEQ_LEAD:   if (rise_i) state_nxt = SEQ_SHIFT;
      SEQ_SHIFT:
        if (rise_i && last_bit) begin
          if (byte_q && !hi_q) state_nxt = SEQ_GAP;
          else if (byte_q)     state_nxt = SEQ_IDLE;
          else                 state_nxt = SEQ_STROBE;
        end
      SEQ_GAP:    if (rise_i) state_nxt = SEQ_SHIFT;
      SEQ_STROBE: if (rise_i) state_nxt = SEQ_IDLE;
      default:    state_nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      bit_q   <= '0;
      hi_q    <= 1'b0;
      byte_q  <= 1'b0;
      frm_n_o <= 1'b1;
      end_n_o <= 1'b1;
    end else begin
      state_q <= state_nxt;
      if (accept_o) begin
        byte_q <= !fmt_word_i;
        hi_q   <= 1'b0;
      end
      if (rise_i && (state_q == SEQ_LEAD || state_q == SEQ_GAP)) bit_q <= '0;
      else if (rise_i && state_q == SEQ_SHIFT && !last_bit)       bit_q <= bit_q + 1'b1;
      if (state_q == SEQ_SHIFT && state_nxt == SEQ_GAP) hi_q <= 1'b1;
      frm_n_o <= (state_nxt != SEQ_SHIFT);
      end_n_o <= !((state_nxt == SEQ_STROBE) || (state_nxt == SEQ_GAP) ||
                   (state_nxt == SEQ_SHIFT && hi_q));
    end
  end
endmodule

// File: rtl/ssp_tx_shift.sv
module ssp_tx_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              adv_i,
  input  logic              clear_i,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst)          sreg_q <= '0;
    else if (load_i)  sreg_q <= data_i;
    else if (clear_i) sreg_q <= '0;
    else if (adv_i)   sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
  end

  assign sdo_o = sreg_q[WORD_W-1];
endmodule

// File: rtl/ssp_rx_shift.sv
module ssp_rx_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_i,
  input  logic              sdi_i,
  input  logic              done_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q  <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (sample_i) sreg_q <= {sreg_q[WORD_W-2:0], sdi_i};
      valid_o <= done_i;
      if (done_i) data_o <= sreg_q;
    end
  end
endmodule

// File: rtl/ssp_framer.sv
module ssp_framer #(
  parameter int WORD_W = 16,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fmt_word_i,
  input  logic              tx_start_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_busy_o,
  input  logic              rx_start_i,
  output logic              rx_busy_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              bclk_o,
  output logic              sdo_o,
  output logic              sdo_frm_n_o,
  output logic              sdo_end_n_o,
  input  logic              sdi_i,
  output logic              sdi_frm_n_o,
  output logic              sdi_end_n_o
);
  logic rise, fall;
  logic tx_acc, tx_in_shift, tx_done;
  logic rx_acc, rx_in_shift, rx_done;

  ssp_clkdiv #(.DIV(DIV)) div_i (
    .clk(clk), .rst(rst), .bclk_o(bclk_o), .rise_o(rise), .fall_o(fall)
  );

  ssp_frame_seq #(.WORD_W(WORD_W)) tx_seq_i (
    .clk(clk), .rst(rst), .rise_i(rise), .start_i(tx_start_i), .fmt_word_i(fmt_word_i),
    .busy_o(tx_busy_o), .accept_o(tx_acc), .in_shift_o(tx_in_shift), .done_o(tx_done),
    .frm_n_o(sdo_frm_n_o), .end_n_o(sdo_end_n_o)
  );

  ssp_tx_shift #(.WORD_W(WORD_W)) tx_sh_i (
    .clk(clk), .rst(rst), .load_i(tx_acc), .data_i(tx_data_i),
    .adv_i(rise && tx_in_shift), .clear_i(tx_done), .sdo_o(sdo_o)
  );

  ssp_frame_seq #(.WORD_W(WORD_W)) rx_seq_i (
    .clk(clk), .rst(rst), .rise_i(rise), .start_i(rx_start_i), .fmt_word_i(fmt_word_i),
    .busy_o(rx_busy_o), .accept_o(rx_acc), .in_shift_o(rx_in_shift), .done_o(rx_done),
    .frm_n_o(sdi_frm_n_o), .end_n_o(sdi_end_n_o)
  );

  ssp_rx_shift #(.WORD_W(WORD_W)) rx_sh_i (
    .clk(clk), .rst(rst), .sample_i(fall && rx_in_shift && !rx_acc), .sdi_i(sdi_i),
    .done_i(rx_done), .data_o(rx_data_o), .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/ssp_framer_chk.sv
module ssp_framer_chk (
  input logic clk,
  input logic rst,
  input logic bclk_o,
  input logic sdo_frm_n_o,
  input logic sdo_end_n_o,
  input logic sdi_frm_n_o,
  input logic sdi_end_n_o,
  input logic tx_busy_o,
  input logic rx_busy_o,
  input logic rx_valid_o
);
  AST_BCLK_HELD_IN_RESET: assert property (@(posedge clk) rst |=> bclk_o); // R7
  AST_BCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk_o) |=> $stable(bclk_o)); // R1
  AST_BCLK_LOW_TWO: assert property (@(posedge clk) disable iff (rst)
    $fell(bclk_o) |=> $stable(bclk_o)); // R1
  AST_SDO_FRAME_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo_frm_n_o) |-> $rose(bclk_o)); // R1
  AST_SDI_FRAME_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdi_frm_n_o) |-> $rose(bclk_o)); // R1
  AST_SDO_END_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    $fell(sdo_end_n_o) |-> $rose(sdo_frm_n_o)); // R4
  AST_SDI_END_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    $fell(sdi_end_n_o) |-> $rose(sdi_frm_n_o)); // R5
  AST_TX_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !tx_busy_o |-> (sdo_frm_n_o && sdo_end_n_o)); // R8
  AST_RX_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rx_busy_o |-> (sdi_frm_n_o && sdi_end_n_o)); // R8
  AST_RX_VALID_ONE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o); // R9
endmodule

bind ssp_framer ssp_framer_chk chk_i (
  .clk(clk), .rst(rst), .bclk_o(bclk_o),
  .sdo_frm_n_o(sdo_frm_n_o), .sdo_end_n_o(sdo_end_n_o),
  .sdi_frm_n_o(sdi_frm_n_o), .sdi_end_n_o(sdi_end_n_o),
  .tx_busy_o(tx_busy_o), .rx_busy_o(rx_busy_o), .rx_valid_o(rx_valid_o)
);

// File: tb/ssp_framer_tb_top.sv
module ssp_framer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fmt_word = 1'b1;
  logic tx_start = 1'b0, rx_start = 1'b0;
  logic [15:0] tx_data = '0;
  logic sdi = 1'b0;
  logic tx_busy, rx_busy, rx_valid, bclk, sdo, sdo_frm_n, sdo_end_n, sdi_frm_n, sdi_end_n;
  logic [15:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ssp_framer dut_i (
    .clk(clk), .rst(rst), .fmt_word_i(fmt_word),
    .tx_start_i(tx_start), .tx_data_i(tx_data), .tx_busy_o(tx_busy),
    .rx_start_i(rx_start), .rx_busy_o(rx_busy), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .bclk_o(bclk), .sdo_o(sdo), .sdo_frm_n_o(sdo_frm_n), .sdo_end_n_o(sdo_end_n),
    .sdi_i(sdi), .sdi_frm_n_o(sdi_frm_n), .sdi_end_n_o(sdi_end_n)
  );

  // element of a transfer, one per bit-clock period: {last, end, frame, bit}
  function automatic logic [3:0] elem(input bit w, input logic [15:0] v, input int i);
    logic [3:0] e;
    e = 4'b0110;
    if (i == 0) e = {1'b0, 1'b1, 1'b1, v[15]};
    else if (w) begin
      if (i <= 16) e = {i == 16, 1'b1, 1'b0, v[16-i]};
      else         e = 4'b0010;
    end else begin
      if (i <= 8)       e = {1'b0, 1'b1, 1'b0, v[16-i]};
      else if (i == 9)  e = {1'b0, 1'b0, 1'b1, v[7]};
      else              e = {i == 17, 1'b0, 1'b0, v[17-i]};
    end
    return e;
  endfunction

  int mcnt;
  logic sclk_e;
  bit t_act, r_act, t_w, r_w;
  int t_idx, r_idx;
  logic [15:0] t_v, r_v;
  bit r_vld_e;

  task automatic adv(inout bit act, inout int idx, input bit w, input logic [15:0] v,
                     output bit leave_last);
    logic [3:0] e;
    leave_last = 1'b0;
    if (act) begin
      if (idx >= 0) begin
        e = elem(w, v, idx);
        leave_last = e[3];
      end
      if (idx == 17) begin act = 1'b0; idx = -1; end
      else idx = idx + 1;
    end
  endtask

  // behavioural reference, advanced on every clock
  always @(posedge clk) begin
    bit tb_pre, rb_pre, tl, rl;
    logic [3:0] e;
    if (rst) begin
      mcnt = 0; sclk_e = 1'b1; t_act = 0; r_act = 0; t_idx = -1; r_idx = -1; r_vld_e = 0;
      sdi <= 1'b0;
    end else begin
      tb_pre = t_act; rb_pre = r_act;
      r_vld_e = 0;
      if (mcnt == 3) begin
        adv(t_act, t_idx, t_w, t_v, tl);
        adv(r_act, r_idx, r_w, r_v, rl);
        if (rl) r_vld_e = 1;
        if (r_act && r_idx >= 0) begin
          e = elem(r_w, r_v, r_idx);
          sdi <= e[0];
        end else sdi <= 1'b0;
      end
      if (tx_start && !tb_pre) begin t_act = 1; t_idx = -1; t_w = fmt_word; t_v = tx_data; end
      if (rx_start && !rb_pre) begin r_act = 1; r_idx = -1; r_w = fmt_word; end
      mcnt = (mcnt + 1) % 4;
      sclk_e = (mcnt < 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    logic [3:0] e;
    if (!rst && !finished) begin
      chk(bclk === sclk_e, "R1 bit clock", bclk, sclk_e);
      chk(tx_busy === t_act, "R8 tx busy", tx_busy, t_act);
      chk(rx_busy === r_act, "R8 rx busy", rx_busy, r_act);
      e = (t_act && t_idx >= 0) ? elem(t_w, t_v, t_idx) : 4'b0110;
      chk(sdo_frm_n === e[1], "R2 R6 send frame", sdo_frm_n, e[1]);
      chk(sdo_end_n === e[2], t_w ? "R4 send end strobe" : "R5 send end strobe", sdo_end_n, e[2]);
      if (t_act && t_idx >= 0 && !(t_w && t_idx == 17))
        chk(sdo === e[0], "R3 serial data bit", sdo, e[0]);
      e = (r_act && r_idx >= 0) ? elem(r_w, r_v, r_idx) : 4'b0110;
      chk(sdi_frm_n === e[1], "R2 R6 receive frame", sdi_frm_n, e[1]);
      chk(sdi_end_n === e[2], r_w ? "R4 receive end strobe" : "R5 receive end strobe", sdi_end_n, e[2]);
      chk(rx_valid === r_vld_e, "R9 rx valid", rx_valid, r_vld_e);
      if (r_vld_e) chk(rx_data === r_v, "R9 rx word", rx_data, r_v);
    end
  end

  task automatic pulse(input bit tx, input bit rx, input bit w, input logic [15:0] td,
                       input logic [15:0] rd);
    @(negedge clk);
    fmt_word = w;
    tx_data = td;
    tx_start = tx;
    rx_start = rx;
    if (rx && !rx_busy) r_v = rd;
    @(negedge clk);
    tx_start = 0;
    rx_start = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (tx_busy || rx_busy);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R7: reset state held over several cycles
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(bclk === 1'b1, "R7 bit clock high in reset", bclk, 1);
      chk(sdo_frm_n && sdi_frm_n && sdo_end_n && sdi_end_n, "R7 frames idle in reset",
          {sdo_frm_n, sdi_frm_n, sdo_end_n, sdi_end_n}, 4'hf);
      chk(!tx_busy && !rx_busy, "R7 busy low in reset", {tx_busy, rx_busy}, 0);
    end
    rst = 0;
    // word format, negative sample, every divider phase for the start
    for (int ph = 0; ph < 4; ph++) begin
      for (int k = 0; k < ph; k++) @(negedge clk);
      pulse(1, 1, 1, 16'h8001 ^ 16'(ph << 4), 16'hA5C3 + 16'(ph));
      wait_idle();
    end
    // byte format, R6 held while the input moves
    pulse(1, 1, 0, 16'h7E81, 16'h3CF0);
    repeat (20) @(negedge clk);
    fmt_word = 1;
    wait_idle();
    pulse(1, 1, 0, 16'hC35A, 16'h0FF1);
    wait_idle();
    // R8: start while busy is ignored
    pulse(1, 1, 1, 16'h1234, 16'h8421);
    repeat (12) @(negedge clk);
    pulse(1, 1, 0, 16'hFFFF, 16'hFFFF);
    chk(tx_busy === 1'b1, "R8 busy after ignored start", tx_busy, 1);
    wait_idle();
    // back-to-back start right after idle
    pulse(1, 0, 1, 16'h0001, 16'h0);
    wait_idle();
    pulse(0, 1, 0, 16'h0, 16'h5AA5);
    wait_idle();
    // R7: reset dropped into the second byte of a transfer
    pulse(1, 1, 0, 16'h9696, 16'h6969);
    repeat (50) @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    chk(bclk === 1'b1, "R7 bit clock high after mid-transfer reset", bclk, 1);
    chk(sdo_frm_n && sdo_end_n && !tx_busy, "R7 send lane idle after reset",
        {sdo_frm_n, sdo_end_n, tx_busy}, 3'b110);
    rst = 0;
    pulse(1, 1, 1, 16'h4000, 16'hBEEF);
    wait_idle();
    repeat (8) @(negedge clk);
    finish_run();
  end
endmodule